// File: doc/BRIEF.md
# Memory Pattern Test Driver

This block drives an external memory controller through a simple local command port to check that the memory stores data correctly. A pass has two phases. In the first phase it writes a run of generated words. In the second phase it reads the same locations back in the same order and compares each returned word, byte by byte, with the value it wrote. The written values come from a pseudo-random generator. The same generator is reseeded before the read phase, so the block stores no copy of the written data.

The addresses can follow either of two modes. The first mode counts up from zero, so the accesses stay inside one bank and one row. The second mode uses a pseudo-random sequence that spreads the accesses across banks and rows, which forces the controller to close and open rows. The block reports three results: a per-lane compare vector for the word that has just been read back, a sticky flag for the whole pass, and a completion flag. The completion flag rises at the end of the read phase whether or not any word failed.

The controller FSM has six states. Idle (`ST_IDLE`) moves to write-command (`ST_WR_CMD`) on an accepted start. A start with a zero length goes straight to the complete state (`ST_DONE`) instead. `ST_WR_CMD` moves to write-drain (`ST_WR_DRAIN`) when the last write command is accepted. `ST_WR_DRAIN` moves to read-command (`ST_RD_CMD`) once every write-data request has been served. `ST_RD_CMD` moves to read-wait (`ST_RD_WAIT`) when the last read command is accepted. Both read states move to `ST_DONE` on the final read beat. `ST_DONE` starts a new pass on start.

Top module: `memtest_engine`

## Requirements
- R1: After reset, no command request is asserted, `test_done` is 0, `pass_sticky` is 1 and `lane_pass` is all ones.
- R2: `start` is accepted only in the idle or complete state. On acceptance, `word_count` and `random_mode` are latched for the whole pass. A `start` or a change of `random_mode` during a running pass has no effect on the commands issued.
- R3: A write or read request is held, with the same address, until a cycle in which `ctl_ready` is 1. Exactly `word_count` write commands are accepted per pass.
- R4: In every cycle with `ctl_wdata_req` high during the write phase, `cmd_wdata` carries the next data value. Data value k (counting from 0) is the seed 0x13579BDF advanced k times. One advance shifts the word right by one bit and, if the bit shifted out was 1, XORs 0x80200003 into the result. `cmd_be` is all ones.
- R5: With `random_mode` 0, the k-th command of a phase uses address k. With `random_mode` 1, it uses the 16-bit seed 0x0ACE advanced k times, where one advance shifts right by one bit and, if the bit shifted out was 1, XORs 0xB400 into the result. Both phases use the same address sequence.
- R6: The first read command is issued only after all `word_count` write-data requests have been served. Exactly `word_count` reads are accepted.
- R7: Read beat i (counting from 0, `ctl_rdata_valid` high) is compared with data value i from R4. In the following cycle, `lane_pass` bit j is 1 exactly when bits 8j+7..8j of the returned word match.
- R8: In every cycle that does not follow a read beat, `lane_pass` is all ones.
- R9: `pass_sticky` is set to 1 when a pass starts, cleared to 0 by any lane mismatch, and then stays 0 until the next start.
- R10: `test_done` goes to 1 in the cycle after the final read beat, even when mismatches occurred. It stays 1, with no commands issued, until the next start.
- R11: A start with `word_count` 0 issues no command and raises `test_done` in the next cycle, with `pass_sticky` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass (from idle or complete) |
| random_mode | input | 1 | 0 = incrementing addresses, 1 = pseudo-random addresses |
| word_count | input | LEN_W | Pass length in words |
| cmd_write_req | output | 1 | Write command request |
| cmd_read_req | output | 1 | Read command request |
| cmd_addr | output | ADDR_W | Command address |
| cmd_wdata | output | DATA_W | Write data, valid while `ctl_wdata_req` is high |
| cmd_be | output | DATA_W/8 | Byte enables |
| ctl_ready | input | 1 | Controller accepts the current command |
| ctl_wdata_req | input | 1 | Controller takes one write-data word |
| ctl_rdata_valid | input | 1 | Read data beat valid |
| ctl_rdata | input | DATA_W | Read data |
| lane_pass | output | DATA_W/8 | Per-lane compare result of the last read beat |
| pass_sticky | output | 1 | Whole-pass pass flag |
| test_done | output | 1 | Read phase finished |

## Verification
The assertions rely on the controller behaving as follows. It raises `ctl_wdata_req` only for write commands it has already accepted. It returns read beats in command order and only for reads it has accepted. It holds `ctl_rdata_valid` low while in reset. The behavioural controller in the bench follows these rules. It queues accepted writes before it requests their data, and it releases each read a few cycles after acceptance, in order. Periodic gaps in `ctl_ready`, `ctl_wdata_req` and `ctl_rdata_valid` exercise the stall paths. A deliberate corruption of one stored byte lane checks that failure reporting works without breaking the protocol.

// File: rtl/memtest_pkg.sv
`timescale 1ns/1ps
package memtest_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_CMD,
        ST_WR_DRAIN,
        ST_RD_CMD,
        ST_RD_WAIT,
        ST_DONE
    } mt_state_e;

    // Feedback mask of a maximal-length right-shifting Galois LFSR
    function automatic logic [63:0] galois_mask(input int width);
        case (width)
            8:       return 64'h0000_0000_0000_00B8;
            16:      return 64'h0000_0000_0000_B400;
            24:      return 64'h0000_0000_00E1_0000;
            32:      return 64'h0000_0000_8020_0003;
            64:      return 64'hD800_0000_0000_0000;
            default: return 64'h0000_0000_0000_0001;
        endcase
    endfunction

endpackage

// File: rtl/memtest_lfsr.sv
`timescale 1ns/1ps
module memtest_lfsr #(
    parameter int               WIDTH = 32,
    parameter logic [WIDTH-1:0] MASK  = '1,
    parameter logic [WIDTH-1:0] SEED  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reseed,
    input  logic             step,
    output logic [WIDTH-1:0] state
);

    logic [WIDTH-1:0] advanced;

    assign advanced = (state >> 1) ^ (state[0] ? MASK : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (reseed) begin
            state <= SEED;
        end else if (step) begin
            state <= advanced;
        end
    end

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

endmodule

// File: rtl/memtest_addr_gen.sv
`timescale 1ns/1ps
module memtest_addr_gen #(
    parameter int                ADDR_W = 16,
    parameter int                LEN_W  = 12,
    parameter logic [ADDR_W-1:0] MASK   = 16'hB400,
    parameter logic [ADDR_W-1:0] SEED   = 16'h0ACE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic              random_mode,
    output logic [ADDR_W-1:0] addr
);

    logic [LEN_W-1:0]  idx;
    logic [ADDR_W-1:0] rnd_addr;
    logic [ADDR_W-1:0] seq_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (restart) begin
            idx <= '0;
        end else if (advance) begin
            idx <= idx + LEN_W'(1);
        end
    end

    memtest_lfsr #(
        .WIDTH (ADDR_W),
        .MASK  (MASK),
        .SEED  (SEED)
    ) i_addr_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (restart),
        .step   (advance),
        .state  (rnd_addr)
    );

    assign seq_addr = ADDR_W'(idx);
    assign addr     = random_mode ? rnd_addr : seq_addr;

endmodule

// File: rtl/memtest_lane_cmp.sv
`timescale 1ns/1ps
module memtest_lane_cmp #(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8
) (
    input  logic [DATA_W-1:0] got,
    input  logic [DATA_W-1:0] want,
    output logic [LANES-1:0]  lane_eq
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (got[8*g +: 8] == want[8*g +: 8]);
    end

endmodule

// File: rtl/memtest_engine.sv
`timescale 1ns/1ps
module memtest_engine
    import memtest_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 32,
    parameter int                LEN_W     = 12,
    parameter logic [DATA_W-1:0] DATA_SEED = 32'h1357_9BDF,
    parameter logic [ADDR_W-1:0] ADDR_SEED = 16'h0ACE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                random_mode,
    input  logic [LEN_W-1:0]    word_count,
    output logic                cmd_write_req,
    output logic                cmd_read_req,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic [DATA_W-1:0]   cmd_wdata,
    output logic [DATA_W/8-1:0] cmd_be,
    input  logic                ctl_ready,
    input  logic                ctl_wdata_req,
    input  logic                ctl_rdata_valid,
    input  logic [DATA_W-1:0]   ctl_rdata,
    output logic [DATA_W/8-1:0] lane_pass,
    output logic                pass_sticky,
    output logic                test_done
);

    localparam int                LANES     = DATA_W / 8;
    localparam logic [DATA_W-1:0] DATA_MASK = DATA_W'(galois_mask(DATA_W));
    localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(galois_mask(ADDR_W));

    mt_state_e        state, state_nx;
    logic [LEN_W-1:0] len_q;
    logic             mode_q;
    logic [LEN_W-1:0] issued;
    logic [LEN_W-1:0] served;
    logic [LEN_W-1:0] beats;

    logic             start_ok;
    logic             cmd_fire;
    logic             wr_phase;
    logic             rd_phase;
    logic             last_issue;
    logic             wdata_take;
    logic             beat;
    logic             last_beat;
    logic             to_read;
    logic             gen_restart;
    logic [DATA_W-1:0] expect_word;
    logic [LANES-1:0]  lane_eq;

    // ---------------- control decode ----------------
    assign start_ok    = start && (state == ST_IDLE || state == ST_DONE);
    assign cmd_fire    = (cmd_write_req || cmd_read_req) && ctl_ready;
    assign wr_phase    = (state == ST_WR_CMD) || (state == ST_WR_DRAIN);
    assign rd_phase    = (state == ST_RD_CMD) || (state == ST_RD_WAIT);
    assign last_issue  = (issued == len_q - LEN_W'(1));
    assign wdata_take  = ctl_wdata_req && wr_phase;
    assign beat        = ctl_rdata_valid && rd_phase;
    assign last_beat   = beat && (beats == len_q - LEN_W'(1));
    assign to_read     = (state == ST_WR_DRAIN) && (served == len_q);
    assign gen_restart = start_ok || to_read;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_nx = (word_count == '0) ? ST_DONE : ST_WR_CMD;
                end
            end
            ST_WR_CMD: begin
                if (cmd_fire && last_issue) begin
                    state_nx = ST_WR_DRAIN;
                end
            end
            ST_WR_DRAIN: begin
                if (to_read) begin
                    state_nx = ST_RD_CMD;
                end
            end
            ST_RD_CMD: begin
                if (last_beat) begin
                    state_nx = ST_DONE;
                end else if (cmd_fire && last_issue) begin
                    state_nx = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (last_beat) begin
                    state_nx = ST_DONE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // ---------------- output decode ----------------
    always_comb begin
        cmd_write_req = 1'b0;
        cmd_read_req  = 1'b0;
        test_done     = 1'b0;
        unique case (state)
            ST_WR_CMD: cmd_write_req = 1'b1;
            ST_RD_CMD: cmd_read_req  = 1'b1;
            ST_DONE:   test_done     = 1'b1;
            default:   ;
        endcase
    end

    // ---------------- pass bookkeeping counters ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            mode_q <= 1'b0;
            issued <= '0;
            served <= '0;
            beats  <= '0;
        end else if (start_ok) begin
            len_q  <= word_count;
            mode_q <= random_mode;
            issued <= '0;
            served <= '0;
            beats  <= '0;
        end else begin
            if (to_read) begin
                issued <= '0;
            end else if (cmd_fire) begin
                issued <= issued + LEN_W'(1);
            end
            if (wdata_take) begin
                served <= served + LEN_W'(1);
            end
            if (beat) begin
                beats <= beats + LEN_W'(1);
            end
        end
    end

    // ---------------- generators ----------------
    memtest_addr_gen #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .MASK   (ADDR_MASK),
        .SEED   (ADDR_SEED)
    ) i_addr_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (gen_restart),
        .advance     (cmd_fire),
        .random_mode (mode_q),
        .addr        (cmd_addr)
    );

    memtest_lfsr #(
        .WIDTH (DATA_W),
        .MASK  (DATA_MASK),
        .SEED  (DATA_SEED)
    ) i_data_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (gen_restart),
        .step   (wdata_take || beat),
        .state  (expect_word)
    );

    assign cmd_wdata = expect_word;
    assign cmd_be    = '1;

    // ---------------- compare and result flags ----------------
    memtest_lane_cmp #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) i_lane_cmp (
        .got     (ctl_rdata),
        .want    (expect_word),
        .lane_eq (lane_eq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_pass   <= '1;
            pass_sticky <= 1'b1;
        end else begin
            lane_pass <= beat ? lane_eq : '1;
            if (start_ok) begin
                pass_sticky <= 1'b1;
            end else if (beat && !(&lane_eq)) begin
                pass_sticky <= 1'b0;
            end
        end
    end

    // ---------------- assertions ----------------
    // R3
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_write_req || cmd_read_req) && !ctl_ready
        |=> $stable(cmd_addr) && $stable(cmd_write_req) && $stable(cmd_read_req));

    // R8
    idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl_rdata_valid) |-> (&lane_pass));

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_sticky && !start |=> !pass_sticky);

    // R9
    lane_fail_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&lane_pass) |-> !pass_sticky);

    // R10
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_done) |-> $past(ctl_rdata_valid) || $past(start));

endmodule

// File: tb/test_memtest_engine.sv
`timescale 1ns/1ps
module test_memtest_engine;

    localparam int          ADDR_W = 16;
    localparam int          DATA_W = 32;
    localparam int          LEN_W  = 12;
    localparam int          LANES  = 4;
    localparam logic [31:0] DSEED  = 32'h1357_9BDF;
    localparam logic [31:0] DMASK  = 32'h8020_0003;
    localparam logic [15:0] ASEED  = 16'h0ACE;
    localparam logic [15:0] AMASK  = 16'hB400;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              random_mode = 1'b0;
    logic [LEN_W-1:0]  word_count = '0;
    logic              cmd_write_req, cmd_read_req;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic [LANES-1:0]  cmd_be;
    logic              tb_ready = 1'b1;
    logic              tb_wdata_req = 1'b0;
    logic              tb_rvalid = 1'b0;
    logic [DATA_W-1:0] tb_rdata = '0;
    logic [LANES-1:0]  lane_pass;
    logic              pass_sticky, test_done;

    always #2.5 clk = ~clk;

    memtest_engine i_memtest_engine (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .random_mode     (random_mode),
        .word_count      (word_count),
        .cmd_write_req   (cmd_write_req),
        .cmd_read_req    (cmd_read_req),
        .cmd_addr        (cmd_addr),
        .cmd_wdata       (cmd_wdata),
        .cmd_be          (cmd_be),
        .ctl_ready       (tb_ready),
        .ctl_wdata_req   (tb_wdata_req),
        .ctl_rdata_valid (tb_rvalid),
        .ctl_rdata       (tb_rdata),
        .lane_pass       (lane_pass),
        .pass_sticky     (pass_sticky),
        .test_done       (test_done)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] dnext(input logic [31:0] x);
        return (x >> 1) ^ (x[0] ? DMASK : 32'h0);
    endfunction

    function automatic logic [15:0] anext(input logic [15:0] x);
        return (x >> 1) ^ (x[0] ? AMASK : 16'h0);
    endfunction

    // ---------------- behavioural controller and scoreboard ----------------
    logic [31:0] mem [logic [15:0]];
    logic [15:0] wq[$];
    logic [15:0] rq_addr[$];
    int          rq_due[$];
    logic [3:0]  exp_lanes_q[$];

    bit          model_on = 0;
    bit          stall_on = 0;
    int          cyc = 0;
    int          exp_n = 0;
    bit          exp_mode = 0;
    int          w_idx, r_idx;
    logic [15:0] w_lfsr, r_lfsr;
    int          wr_acc, rd_acc, wd_served, beats_sent;
    logic [31:0] wd_exp, rd_exp;
    bit          exp_sticky = 1;
    bit          corrupt_on = 0;
    logic [15:0] corrupt_addr;
    logic [31:0] corrupt_mask;
    bit          beat_prev = 0;
    bit          last_prev = 0;

    always @(negedge clk) begin
        if (model_on) begin
            logic [15:0] a;
            logic [31:0] d;
            logic [3:0]  ln;
            cyc++;
            // monitor: results of the beat driven one cycle earlier
            if (beat_prev) begin
                ln = exp_lanes_q.pop_front();
                check(lane_pass == ln, "R7", "lane_pass after beat", 64'(lane_pass), 64'(ln));
                check(pass_sticky == exp_sticky, "R9", "pass_sticky after beat",
                      64'(pass_sticky), 64'(exp_sticky));
                check(test_done == last_prev, "R10", "test_done after beat",
                      64'(test_done), 64'(last_prev));
            end else begin
                check(lane_pass == 4'hF, "R8", "lane_pass without beat", 64'(lane_pass), 64'hF);
            end
            // write-data requests for already accepted writes
            tb_wdata_req = 1'b0;
            if (wq.size() > 0 && (cyc % 3) != 1) begin
                a = wq.pop_front();
                tb_wdata_req = 1'b1;
                check(cmd_wdata == wd_exp, "R4", "write data", 64'(cmd_wdata), 64'(wd_exp));
                check(cmd_be == 4'hF, "R4", "byte enables", 64'(cmd_be), 64'hF);
                mem[a] = cmd_wdata;
                wd_exp = dnext(wd_exp);
                wd_served++;
            end
            // read returns, in order
            tb_rvalid = 1'b0;
            beat_prev = 0;
            if (rq_addr.size() > 0 && rq_due[0] <= cyc && (cyc % 4) != 2) begin
                a = rq_addr.pop_front();
                void'(rq_due.pop_front());
                d = mem.exists(a) ? mem[a] : 32'h0;
                if (corrupt_on && a == corrupt_addr) d = d ^ corrupt_mask;
                tb_rdata  = d;
                tb_rvalid = 1'b1;
                for (int j = 0; j < 4; j++) ln[j] = (d[8*j +: 8] == rd_exp[8*j +: 8]);
                exp_lanes_q.push_back(ln);
                if (ln != 4'hF) exp_sticky = 0;
                rd_exp = dnext(rd_exp);
                beats_sent++;
                beat_prev = 1;
                last_prev = (beats_sent == exp_n);
            end
            // ready for the coming edge, then acceptance on that edge
            tb_ready = (stall_on && (cyc % 5) == 3) ? 1'b0 : 1'b1;
            if (cmd_write_req && tb_ready) begin
                a = exp_mode ? w_lfsr : 16'(w_idx);
                check(cmd_addr == a, "R5", "write address", 64'(cmd_addr), 64'(a));
                wq.push_back(cmd_addr);
                wr_acc++;
                w_idx++;
                w_lfsr = anext(w_lfsr);
            end
            if (cmd_read_req && tb_ready) begin
                if (rd_acc == 0)
                    check(wd_served == exp_n, "R6", "data served before first read",
                          64'(wd_served), 64'(exp_n));
                a = exp_mode ? r_lfsr : 16'(r_idx);
                check(cmd_addr == a, "R5", "read address", 64'(cmd_addr), 64'(a));
                rq_addr.push_back(cmd_addr);
                rq_due.push_back(cyc + 3);
                rd_acc++;
                r_idx++;
                r_lfsr = anext(r_lfsr);
            end
        end
    end

    // ---------------- pass driver ----------------
    task automatic run_pass(input int n, input bit rnd, input bit stall, input bit corrupt,
                            input int cidx, input logic [31:0] cmask, input bit poke);
        logic [15:0] ca;
        int          waited;
        exp_n = n; exp_mode = rnd; stall_on = stall;
        w_idx = 0; r_idx = 0; w_lfsr = ASEED; r_lfsr = ASEED;
        wr_acc = 0; rd_acc = 0; wd_served = 0; beats_sent = 0;
        wd_exp = DSEED; rd_exp = DSEED; exp_sticky = 1;
        ca = ASEED;
        for (int k = 0; k < cidx; k++) ca = anext(ca);
        corrupt_addr = rnd ? ca : 16'(cidx);
        corrupt_mask = cmask;
        corrupt_on = corrupt;
        @(negedge clk);
        word_count = LEN_W'(n); random_mode = rnd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n > 0) check(test_done == 1'b0, "R10", "done cleared by start", 64'(test_done), 64'h0);
        if (poke) begin
            repeat (3) @(negedge clk);
            random_mode = ~rnd; start = 1'b1;   // R2: ignored while running
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!test_done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check(waited < 5000, "R10", "completion seen", 64'(waited), 64'd5000);
        repeat (4) @(negedge clk);
        check(wr_acc == n, "R3", "writes accepted", 64'(wr_acc), 64'(n));
        check(rd_acc == n, "R6", "reads accepted", 64'(rd_acc), 64'(n));
        check(beats_sent == n, "R10", "beats before done", 64'(beats_sent), 64'(n));
        check(pass_sticky == exp_sticky, "R9", "sticky at end", 64'(pass_sticky), 64'(exp_sticky));
        check(test_done == 1'b1 && !cmd_write_req && !cmd_read_req, "R10", "done held, quiet",
              64'({test_done, cmd_write_req, cmd_read_req}), 64'h4);
        corrupt_on = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!cmd_write_req && !cmd_read_req, "R1", "requests in reset",
              64'({cmd_write_req, cmd_read_req}), 64'h0);
        check(test_done == 1'b0, "R1", "done in reset", 64'(test_done), 64'h0);
        check(pass_sticky == 1'b1, "R1", "sticky in reset", 64'(pass_sticky), 64'h1);
        check(lane_pass == 4'hF, "R1", "lanes in reset", 64'(lane_pass), 64'hF);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1;
        repeat (3) @(negedge clk);
        check(!cmd_write_req && !test_done, "R1", "idle after reset",
              64'({cmd_write_req, test_done}), 64'h0);

        run_pass(10, 1'b0, 1'b0, 1'b0, 0, 32'h0, 1'b0);           // sequential, clean
        run_pass(20, 1'b1, 1'b1, 1'b0, 0, 32'h0, 1'b0);           // random, stalls
        run_pass(12, 1'b0, 1'b1, 1'b1, 10, 32'h0000_FF00, 1'b0);  // R7/R9: lane 1 corrupted near end
        check(pass_sticky == 1'b0, "R9", "sticky low after mismatch", 64'(pass_sticky), 64'h0);
        run_pass(15, 1'b1, 1'b0, 1'b0, 0, 32'h0, 1'b1);           // R2: start and mode poked mid-pass
        check(pass_sticky == 1'b1, "R9", "sticky restored on new pass", 64'(pass_sticky), 64'h1);

        // R11: zero length
        @(negedge clk);
        word_count = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(test_done == 1'b1, "R11", "done after empty pass", 64'(test_done), 64'h1);
        check(pass_sticky == 1'b1, "R11", "sticky after empty pass", 64'(pass_sticky), 64'h1);
        repeat (5) begin
            @(negedge clk);
            check(!cmd_write_req && !cmd_read_req, "R11", "no commands on empty pass",
                  64'({cmd_write_req, cmd_read_req}), 64'h0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule